// File: doc/BRIEF.md
# Prescaled Timer with Compare Interrupt

This block is a 16-bit free-running or periodic timer. Its input clock first passes through a prescaler that divides by 1, 2, 4 or 8. The counter advances by one each time the prescaler reaches its terminal count. Software programs the timer through a plain write strobe with an address and data, and reads it back through a combinational read port. Software can select the run mode, choose the divide ratio, load the counter directly, program a compare value, and clear the overflow flag.

There are two ways to restart the count, and they give different timing. A dedicated clear input zeroes both the counter and the prescaler, so the first increment comes exactly one full prescaler period later. A direct write to the counter changes only the counter and leaves the prescaler phase running. The next increment therefore comes whenever the prescaler would have rolled over anyway, which can be as soon as one input clock later. This choice lets a node that gets a sync event either restart a precise delay or keep its existing tick cadence.

Two interrupt flags are driven as outputs. The compare flag sets when the counter counts onto the compare value, and hardware clears it when the interrupt is acknowledged. The overflow flag sets when the counter wraps in continuous mode, and only a software write clears it.

Top module: `prescaled_timer`

Register map (write `wr_addr`/`wr_data` with `wr_en`, read via `rd_addr`/`rd_data`):

| Address | Write | Read |
|---|---|---|
| 0 | bits[1:0] mode (0 stop, 1 up, 2 continuous, 3 stop); bits[5:4] divide select (0→/1, 1→/2, 2→/4, 3→/8) | same layout |
| 1 | loads the counter | counter value |
| 2 | compare value | compare value |
| 3 | writing 1 to bit1 clears the overflow flag | bit0 compare flag, bit1 overflow flag |

## Requirements
- R1: After reset, the mode is stop (0), the divide select, counter and compare register are zero, and both flags read zero.
- R2: In a run mode with divide select s, the counter advances by exactly one every 2^s input clocks.
- R3: A write to address 1 sets the counter at that edge and leaves the prescaler phase untouched. With divide by 8, a load made 6 clocks after a tick is followed by the next increment 2 clocks later.
- R4: A one-cycle pulse on `tmr_clr` zeroes the counter and the prescaler at that edge. The first increment then follows exactly N input clocks later, where N is the divide ratio.
- R5: When a load coincides with a prescaled tick, the loaded value wins. When `tmr_clr` coincides with a load, the counter becomes zero.
- R6: In up mode (1), the counter counts up to the compare value, holds it for one tick period, and then goes to zero on the next tick.
- R7: In continuous mode (2), the counter counts from 0xFFFF to 0x0000 on a tick, and the overflow flag (`ovf_irq`, read bit1) sets at that same edge.
- R8: The compare flag (`cmp_irq`, read bit0) sets at the edge where a tick brings the counter onto the compare value. A one-cycle `irq_ack` clears it at the next edge, and a new match in that same cycle keeps it set.
- R9: The overflow flag is cleared only by writing 1 to bit1 of address 3. `irq_ack` and writes with bit1 at zero leave it set.
- R10: In stop mode (0 or 3), neither the counter nor the prescaler advances, but counter loads and `tmr_clr` still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| tmr_clr | input | 1 | Clears counter and prescaler |
| irq_ack | input | 1 | Compare interrupt acknowledge |
| cmp_irq | output | 1 | Compare-match interrupt flag |
| ovf_irq | output | 1 | Overflow interrupt flag |

## Verification
The bench contrasts the two restart paths under divide by 8. A design that resets the prescaler on a counter load would show the next increment 8 clocks later instead of 2. A design that leaves the prescaler alone on clear would increment early. It loads the counter in the exact cycle the prescaler rolls over and raises clear together with a load, so a wrong priority shows up as an off-by-one or a non-zero value. It also checks the up-mode wrap one tick after the match, the 0xFFFF wrap together with the overflow flag, that acknowledge clears only the compare flag, and that stop mode freezes the count while loads and clear still act.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  parameter int CNT_W   = 16;
  parameter int SEL_W   = 2;
  parameter int PRE_W   = (2 ** SEL_W) - 1;

  typedef enum logic [1:0] {
    M_STOP = 2'd0,
    M_UP   = 2'd1,
    M_CONT = 2'd2,
    M_HALT = 2'd3
  } tmr_mode_e;

  // terminal count of the prescaler for a given divide select
  function automatic logic [PRE_W-1:0] pre_last(input logic [SEL_W-1:0] sel);
    logic [PRE_W:0] ratio;
    ratio = (PRE_W+1)'(1) << sel;
    return PRE_W'(ratio - 1'b1);
  endfunction

  function automatic logic is_running(input tmr_mode_e m);
    return (m == M_UP) || (m == M_CONT);
  endfunction

  // next counter value when a tick advances it
  function automatic logic [CNT_W-1:0] advance(input tmr_mode_e m,
                                               input logic [CNT_W-1:0] cur,
                                               input logic [CNT_W-1:0] lim);
    if (m == M_UP && cur == lim) return '0;
    return cur + 1'b1;
  endfunction
endpackage

// File: rtl/ptm_prescaler.sv
module ptm_prescaler
  import ptm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic             at_last;

  assign at_last = (pre_q == pre_last(sel));
  assign tick    = run && at_last && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n)        pre_q <= '0;
    else if (clr)      pre_q <= '0;
    else if (run)      pre_q <= at_last ? '0 : pre_q + 1'b1;
  end

  a_r4_clear_resets_phase: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pre_q == '0);
  a_r10_prescaler_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/ptm_counter.sv
module ptm_counter
  import ptm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode,
  input  logic             tick,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt,
  output logic             cmp_evt,
  output logic             ovf_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] adv_val;
  logic             step;

  assign adv_val = advance(mode, cnt_q, cmp_val);
  assign step    = tick && !clr && !load;
  assign cmp_evt = step && (adv_val == cmp_val);
  assign ovf_evt = step && (mode == M_CONT) && (cnt_q == '1);
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (step)  cnt_q <= adv_val;
  end

  a_r5_clear_beats_load: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  a_r5_load_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> cnt_q == $past(load_val));
  a_r6_up_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == M_UP && cnt_q == cmp_val) |=> cnt_q == '0);
  a_r7_cont_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> cnt_q == '0);
  a_r10_counter_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_running(mode) && !clr && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/ptm_flags.sv
module ptm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_evt,
  input  logic ovf_evt,
  input  logic ack,
  input  logic ovf_clr,
  output logic cmp_flag,
  output logic ovf_flag
);
  logic cmp_q, ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (cmp_evt)      cmp_q <= 1'b1;
      else if (ack)     cmp_q <= 1'b0;
      if (ovf_evt)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assign cmp_flag = cmp_q;
  assign ovf_flag = ovf_q;

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cmp_evt) |=> !cmp_q);
  a_r8_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> cmp_q);
  a_r9_ack_keeps_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  a_r7_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_q);
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import ptm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic        tmr_clr,
  input  logic        irq_ack,
  output logic        cmp_irq,
  output logic        ovf_irq
);
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_CMP   = 2'd2;
  localparam logic [1:0] A_FLAGS = 2'd3;

  tmr_mode_e        mode_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt;
  logic             tick, cmp_evt, ovf_evt, run;
  logic             load, ovf_clr;
  logic             unused_bits;

  assign run     = is_running(mode_q);
  assign load    = wr_en && (wr_addr == A_COUNT);
  assign ovf_clr = wr_en && (wr_addr == A_FLAGS) && wr_data[1];
  assign unused_bits = ^{wr_data[15:6], wr_data[3:2], wr_data[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_STOP;
      sel_q  <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        mode_q <= tmr_mode_e'(wr_data[1:0]);
        sel_q  <= wr_data[4 +: SEL_W];
      end
      if (wr_addr == A_CMP) cmp_q <= wr_data[CNT_W-1:0];
    end
  end

  ptm_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(tmr_clr), .sel(sel_q), .tick(tick)
  );

  ptm_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .tick(tick), .clr(tmr_clr),
    .load(load), .load_val(wr_data[CNT_W-1:0]), .cmp_val(cmp_q),
    .cnt(cnt), .cmp_evt(cmp_evt), .ovf_evt(ovf_evt)
  );

  ptm_flags u_flg (
    .clk(clk), .rst_n(rst_n), .cmp_evt(cmp_evt), .ovf_evt(ovf_evt),
    .ack(irq_ack), .ovf_clr(ovf_clr), .cmp_flag(cmp_irq), .ovf_flag(ovf_irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = {10'd0, sel_q, 2'b00, mode_q};
      A_COUNT: rd_data = cnt;
      A_CMP:   rd_data = cmp_q;
      default: rd_data = {14'd0, ovf_irq, cmp_irq};
    endcase
  end

  a_r1_stop_after_reset: assert property (@(posedge clk)
    !rst_n |=> (mode_q == M_STOP && cmp_q == '0));
endmodule

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        tmr_clr = 1'b0;
  logic        irq_ack = 1'b0;
  logic        cmp_irq, ovf_irq;
  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  prescaled_timer i_prescaled_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tmr_clr(tmr_clr), .irq_ack(irq_ack), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    tmr_clr = 1'b1;
    @(negedge clk);
    tmr_clr = 1'b0;
  endtask

  function automatic logic [15:0] ctrl(input int mode, input int sel);
    return 16'(mode) | (16'(sel) << 4);
  endfunction

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    #0.1;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); check("R1 count", v, 16'h0000);
    rd(2'd2, v); check("R1 compare", v, 16'h0000);
    rd(2'd3, v); check("R1 flags", v, 16'h0000);
  endtask

  // clear then divide by 8: first increment 8 clocks later; then load keeps phase
  task automatic t_clear_and_load();
    logic [15:0] v;
    wr(2'd0, ctrl(2, 3));
    pulse_clr();
    step(7); rd(2'd1, v); check("R4 still zero 7 clocks after clear", v, 16'd0);
    step(1); rd(2'd1, v); check("R4 increment at 8 clocks", v, 16'd1);
    step(8); rd(2'd1, v); check("R2 divide by 8 cadence", v, 16'd2);
    step(5);
    wr(2'd1, 16'd100);
    rd(2'd1, v); check("R3 load value", v, 16'd100);
    step(1); rd(2'd1, v); check("R3 no early tick", v, 16'd100);
    step(1); rd(2'd1, v); check("R3 phase kept, tick 2 clocks after load", v, 16'd101);
    step(7);
    wr(2'd1, 16'd500);
    rd(2'd1, v); check("R5 load beats coincident tick", v, 16'd500);
    tmr_clr = 1'b1;
    wr(2'd1, 16'd77);
    tmr_clr = 1'b0;
    rd(2'd1, v); check("R5 clear beats load", v, 16'd0);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    wr(2'd0, ctrl(3, 2));
    wr(2'd1, 16'd1234);
    step(10); rd(2'd1, v); check("R10 frozen with load applied", v, 16'd1234);
    pulse_clr();
    step(10); rd(2'd1, v); check("R10 clear works when stopped", v, 16'd0);
    wr(2'd0, ctrl(2, 2));
    step(3); rd(2'd1, v); check("R2 divide by 4 before tick", v, 16'd0);
    step(1); rd(2'd1, v); check("R2 divide by 4 first tick", v, 16'd1);
    step(4); rd(2'd1, v); check("R2 divide by 4 second tick", v, 16'd2);
  endtask

  task automatic t_up();
    logic [15:0] v;
    wr(2'd0, ctrl(0, 0));
    pulse_clr();
    wr(2'd2, 16'd5);
    wr(2'd0, ctrl(1, 0));
    step(4); rd(2'd1, v); check("R6 count 4", v, 16'd4);
    check("R8 flag clear before match", {15'd0, cmp_irq}, 16'd0);
    step(1); rd(2'd1, v); check("R6 reaches compare", v, 16'd5);
    check("R8 flag set on match", {15'd0, cmp_irq}, 16'd1);
    step(1); rd(2'd1, v); check("R6 wraps to zero", v, 16'd0);
    step(1);
    check("R8 flag held without ack", {15'd0, cmp_irq}, 16'd1);
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    check("R8 ack clears flag", {15'd0, cmp_irq}, 16'd0);
    // count now 2; match at 5 three clocks on: ack in that cycle loses
    step(2);
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    check("R8 match wins over ack", {15'd0, cmp_irq}, 16'd1);
  endtask

  task automatic t_cont();
    logic [15:0] v;
    wr(2'd0, ctrl(0, 0));
    wr(2'd1, 16'hFFFD);
    wr(2'd0, ctrl(2, 0));
    step(2); rd(2'd1, v); check("R7 at FFFF", v, 16'hFFFF);
    check("R7 no overflow yet", {15'd0, ovf_irq}, 16'd0);
    step(1); rd(2'd1, v); check("R7 wraps to 0", v, 16'h0000);
    check("R7 overflow set", {15'd0, ovf_irq}, 16'd1);
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    check("R9 ack leaves overflow", {15'd0, ovf_irq}, 16'd1);
    wr(2'd3, 16'h0001);
    rd(2'd3, v); check("R9 write bit1=0 leaves overflow", v & 16'h2, 16'h2);
    wr(2'd3, 16'h0002);
    rd(2'd3, v); check("R9 write bit1=1 clears overflow", v & 16'h2, 16'h0);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_clear_and_load();
    t_stop();
    t_up();
    t_cont();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule